// File: doc/BRIEF.md
# Fractional Pixel Width Scaler

This block sets how many physical pixels one logical pixel spans, and the span need not be a whole number. An unsigned scale value is added into a fixed-point phase accumulator on every physical pixel. The accumulator has 7 fractional bits, so 128 is one whole logical pixel. Each time the sum crosses a multiple of 128, the downstream character or bitmap generator is told to step forward. A large scale can cross two units in one physical pixel.

With scale 1 a logical pixel is 128 physical pixels wide. With scale 255 it is just over half a physical pixel wide. A scale of 51 gives about 2.5 physical pixels per logical pixel. No filtering is done: a logical pixel that falls between physical pixels is dropped or repeated. A line-start pulse clears the phase, so every raster line begins with the same phase.

Top module: `pixel_width_scaler`

## Requirements
- R1: While reset is held, and on the first clock after it, `adv` is 0 and `adv_cnt` is 0.
- R2: On a clock with `pix_en` high, the step is computed from a base phase and `scale`. The sum is base + `scale`, and the new phase is the sum modulo 128. `adv_cnt` becomes floor(sum / 128) one clock later.
- R3: `adv_cnt` is never above 2. `adv` is 1 exactly when `adv_cnt` is non-zero.
- R4: With `scale` = 1 after a line start, the first advance follows the 128th enabled pixel. The advance count is exactly 1 per 128 enabled pixels.
- R5: With `scale` = 0, `adv_cnt` stays 0 and the phase does not change.
- R6: `line_start` clears the phase to 0. If `pix_en` is high in the same clock, that pixel accumulates from a base of 0.
- R7: On a clock with `pix_en` low, `adv_cnt` is 0 one clock later and the phase is held.
- R8: With `scale` of 128 or more, every enabled pixel yields an `adv_cnt` of at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Physical pixel domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | One physical pixel is output this clock |
| line_start | input | 1 | Clears the phase at the start of a raster line |
| scale | input | 8 | Phase increment per physical pixel; 128 is one logical pixel |
| adv | output | 1 | Step the pixel generator (registered) |
| adv_cnt | output | 2 | Number of logical pixels to step, 0 to 2 (registered) |

## Verification
Four directed patterns are run:

- **Scale 1** checks the slowest width and that the phase carries across 128 pixels.
- **Scale 0** checks the frozen case.
- **Scale 255** checks double steps.
- **Scale 51** checks a 2.5-pixel width, with its uneven 2/3 spacing between advances.

Random scale, enable and line-start traffic is then compared clock by clock against a bench model of the phase. This catches lost remainders, a wrong priority between line start and the pixel step, and phase changes while the enable is low.

// File: rtl/pixel_width_scaler.sv
module pixel_width_scaler #(
  parameter int SCALE_W = 8,
  parameter int FRAC_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_en,
  input  logic               line_start,
  input  logic [SCALE_W-1:0] scale,
  output logic               adv,
  output logic [$clog2((((1<<FRAC_W)-1+(1<<SCALE_W)-1)>>FRAC_W)+1)-1:0] adv_cnt
);
  localparam int SUM_W = ((SCALE_W > FRAC_W) ? SCALE_W : FRAC_W) + 1;
  localparam int CNT_W = $clog2((((1<<FRAC_W)-1+(1<<SCALE_W)-1)>>FRAC_W)+1);

  logic [FRAC_W-1:0] phase;
  logic [FRAC_W-1:0] base;
  logic [SUM_W-1:0]  sum;

  assign base = line_start ? '0 : phase;
  assign sum  = SUM_W'(base) + SUM_W'(scale);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      adv     <= 1'b0;
      adv_cnt <= '0;
    end else if (pix_en) begin
      phase   <= sum[FRAC_W-1:0];
      adv_cnt <= CNT_W'(sum >> FRAC_W);
      adv     <= sum >= SUM_W'(1 << FRAC_W);
    end else begin
      phase   <= base;
      adv_cnt <= '0;
      adv     <= 1'b0;
    end
  end
endmodule

// File: rtl/pixel_width_scaler_chk.sv
module pixel_width_scaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_en,
  input logic [7:0] scale,
  input logic       adv,
  input logic [1:0] adv_cnt
);
  a_r3_cnt_max: assert property (@(posedge clk) disable iff (!rst_n) adv_cnt <= 2'd2);
  a_r3_strobe: assert property (@(posedge clk) disable iff (!rst_n) adv == (adv_cnt != 2'd0));
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(pix_en)) |-> adv_cnt == 2'd0);
  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pix_en) && $past(scale) == 8'd0) |-> adv_cnt == 2'd0);
  a_r8_big: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pix_en) && $past(scale) >= 8'd128) |-> adv_cnt != 2'd0);
endmodule

bind pixel_width_scaler pixel_width_scaler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .scale(scale), .adv(adv), .adv_cnt(adv_cnt)
);

// File: tb/pixel_width_scaler_test.sv
module pixel_width_scaler_test;
  logic clk = 0, rst_n = 0, pix_en = 0, line_start = 0;
  logic [7:0] scale = 0;
  logic adv;
  logic [1:0] adv_cnt;
  int total = 0, bad = 0;
  int m_phase = 0;
  int exp_cnt = 0;

  always #5 clk = ~clk;

  pixel_width_scaler uut (.clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .line_start(line_start), .scale(scale), .adv(adv), .adv_cnt(adv_cnt));

  function automatic int model_step(input bit en, input bit ls, input int sc);
    int b, s;
    b = ls ? 0 : m_phase;
    if (en) begin
      s = b + sc;
      m_phase = s % 128;
      return s / 128;
    end
    m_phase = b;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input bit en, input bit ls, input int sc, input string tag);
    pix_en = en; line_start = ls; scale = 8'(sc);
    exp_cnt = model_step(en, ls, sc);
    @(negedge clk);
    chk(tag, adv_cnt, exp_cnt);
    chk("R3", adv, exp_cnt != 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int adv_sum, first;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", adv, 0); chk("R1", adv_cnt, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", adv_cnt, 0);

    // R4: scale 1, first advance on the 128th pixel
    first = -1; adv_sum = 0;
    step(1, 1, 1, "R6");
    for (int i = 2; i <= 256; i++) begin
      step(1, 0, 1, "R4");
      if (adv_cnt != 0 && first < 0) first = i;
      adv_sum += adv_cnt;
    end
    chk("R4", first, 128);
    chk("R4", adv_sum, 2);

    // R5: scale 0 freezes
    step(1, 1, 0, "R5");
    adv_sum = 0;
    for (int i = 0; i < 50; i++) begin step(1, 0, 0, "R5"); adv_sum += adv_cnt; end
    chk("R5", adv_sum, 0);

    // R8: scale 255, double steps
    step(1, 1, 255, "R8");
    chk("R8", adv_cnt, 1);
    step(1, 0, 255, "R8");
    chk("R8", adv_cnt, 2);
    for (int i = 0; i < 20; i++) step(1, 0, 255, "R8");

    // R2: scale 51 ~ 2.5 px per logical pixel
    step(1, 1, 51, "R2");
    adv_sum = 0;
    for (int i = 1; i < 100; i++) begin step(1, 0, 51, "R2"); adv_sum += adv_cnt; end
    chk("R2", adv_sum, (100 * 51) / 128);

    // R7: enable low holds the phase
    step(1, 1, 100, "R7");
    step(0, 0, 100, "R7");
    chk("R7", adv_cnt, 0);
    step(1, 0, 30, "R7");
    chk("R7", adv_cnt, 1);

    // R6: line start mid-phase resets the base
    step(1, 0, 120, "R6");
    step(1, 1, 120, "R6");
    chk("R6", adv_cnt, 0);
    step(0, 1, 0, "R6");
    step(1, 0, 127, "R6");
    chk("R6", adv_cnt, 0);

    for (int i = 0; i < 20000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 80, r > 95, $urandom_range(0, 255), "R2");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule